// File: doc/BRIEF.md
# Memory Base Address Register with Inbound Decode

This block holds one memory-space base address register and the inbound decoder that goes with it. The register is 32 bits wide or a 64-bit pair that takes two 32-bit slots. Its window size is a power of two fixed by a parameter. There is no length field. Address bits below the window size are tied to zero, so enumeration software learns the size by writing all-ones and reading the value back.

Configuration software writes and reads the register one 32-bit slot at a time. Slot 0 carries the low word together with four read-only type bits. Slot 1 carries the high word of a 64-bit register.

Each cycle, the decoder compares an inbound request address with the programmed base. It ignores the bits inside the window. One clock later it returns a hit flag and the offset of the request within the window. Hits are blocked while memory decoding is disabled. The block has no state machine. It has a register-update process and a registered decode stage, each with its own clocked process and its own combinational next-value logic.

Top module: `bar_window`

## Requirements
- R1: After reset the stored base is zero, slot 0 reads back as only its type bits, slot 1 reads zero, and `hit` is low.
- R2: Slot 0 bits [3:0] are read-only type bits. Bit 0 is 0 (memory space). Bits [2:1] are 2'b10 for a 64-bit register and 2'b00 for a 32-bit one. Bit 3 equals the `PREFETCH` parameter.
- R3: Address bits below `SIZE_LOG2` always read as zero, whatever is written to them. For a 64-bit, 256-byte, prefetchable register, writing all-ones reads back 0xFFFFFF0C in slot 0 and 0xFFFFFFFF in slot 1.
- R4: In a 64-bit register, a write to slot 1 (`cfg_wr_slot`=1) changes only base bits [63:32], and a write to slot 0 changes only bits [31:0].
- R5: In a 32-bit register, slot 1 always reads zero and writes to it have no effect.
- R6: `hit` is high in the cycle after a request only if `req_valid` and `mem_en` were high and `req_addr`, with its low `SIZE_LOG2` bits ignored, equalled the stored base.
- R7: When `hit` is high, `hit_offset` equals bits [`SIZE_LOG2`-1:0] of the request address from the previous cycle.
- R8: While `mem_en` is low, no request produces a hit.
- R9: A request misses when any address bit at or above `SIZE_LOG2` differs from the base. This includes the first bit above the window, and address bits [63:32] being nonzero for a 32-bit register.
- R10: A cycle with `req_valid` low gives `hit` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_slot | input | 1 | Write slot: 0 low word, 1 high word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_slot | input | 1 | Read slot: 0 low word, 1 high word |
| cfg_rdata | output | 32 | Read data of the selected slot (combinational) |
| mem_en | input | 1 | Memory decode enable |
| req_valid | input | 1 | Inbound request valid |
| req_addr | input | 64 | Inbound request address |
| hit | output | 1 | Request targeted this window (registered) |
| hit_offset | output | SIZE_LOG2 | Offset within the window (registered) |

## Verification
The bench builds two instances of the block. The first is a 64-bit, prefetchable, 256-byte register. It covers the all-ones sizing read-back, independent updates of the two slots, and decode at both edges of the window as well as just outside them. The second is a 32-bit, non-prefetchable, 4 KB register. It covers the slot that is tied to zero, the other type encoding, a 12-bit offset, and a miss caused by nonzero high address bits.

// File: rtl/bar_pkg.sv
package bar_pkg;
    localparam int SLOT_W = 32;
    localparam int ADDR_W = 64;

    // Read-only attribute nibble of slot 0: [0] memory, [2:1] width, [3] prefetch
    function automatic logic [3:0] attr_bits(input logic wide, input logic pf);
        attr_bits = {pf, (wide ? 2'b10 : 2'b00), 1'b0};
    endfunction
endpackage

// File: rtl/bar_store.sv
module bar_store
    import bar_pkg::*;
#(
    parameter bit IS_64     = 1'b1,
    parameter int SIZE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_slot,
    input  logic [SLOT_W-1:0] wdata,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] SPAN     = (64'd1 << SIZE_LOG2) - 64'd1;
    localparam logic [ADDR_W-1:0] WIDTH_MK = IS_64 ? {ADDR_W{1'b1}} : 64'h0000_0000_FFFF_FFFF;
    localparam logic [ADDR_W-1:0] KEEP     = ~SPAN & WIDTH_MK;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_d;

    always_comb begin
        base_d = base_q;
        if (wr_en) begin
            if (wr_slot) begin
                base_d[63:32] = wdata & KEEP[63:32];
            end else begin
                base_d[31:0] = wdata & KEEP[31:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base = base_q;

    p_hi_write_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot) |=> $stable(base_q[31:0]));
    p_lo_write_keeps_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_slot) |=> $stable(base_q[63:32]));
endmodule

// File: rtl/bar_decode.sv
module bar_decode
    import bar_pkg::*;
#(
    parameter int SIZE_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    base,
    input  logic                 mem_en,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 hit,
    output logic [SIZE_LOG2-1:0] offset
);
    localparam logic [ADDR_W-1:0] MATCH = ~((64'd1 << SIZE_LOG2) - 64'd1);

    logic                 hit_d;
    logic                 hit_q;
    logic [SIZE_LOG2-1:0] off_q;

    always_comb begin
        hit_d = req_valid && mem_en && ((req_addr & MATCH) == base);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            off_q <= '0;
        end else begin
            hit_q <= hit_d;
            off_q <= req_addr[SIZE_LOG2-1:0];
        end
    end

    assign hit    = hit_q;
    assign offset = off_q;

    p_hit_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(mem_en));
    p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(req_valid));
    p_offset_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (off_q == $past(req_addr[SIZE_LOG2-1:0])));
endmodule

// File: rtl/bar_window.sv
module bar_window
    import bar_pkg::*;
#(
    parameter bit IS_64     = 1'b1,
    parameter bit PREFETCH  = 1'b1,
    parameter int SIZE_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_wr_slot,
    input  logic [31:0]          cfg_wdata,
    input  logic                 cfg_rd_slot,
    output logic [31:0]          cfg_rdata,
    input  logic                 mem_en,
    input  logic                 req_valid,
    input  logic [63:0]          req_addr,
    output logic                 hit,
    output logic [SIZE_LOG2-1:0] hit_offset
);
    localparam logic [3:0]  ATTR    = attr_bits(IS_64, PREFETCH);
    localparam logic [63:0] SPAN    = (64'd1 << SIZE_LOG2) - 64'd1;
    localparam logic [31:0] LO_SPAN = SPAN[31:0];

    logic [ADDR_W-1:0] base;

    bar_store #(.IS_64(IS_64), .SIZE_LOG2(SIZE_LOG2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_slot (cfg_wr_slot),
        .wdata   (cfg_wdata),
        .base    (base)
    );

    bar_decode #(.SIZE_LOG2(SIZE_LOG2)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (base),
        .mem_en    (mem_en),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit       (hit),
        .offset    (hit_offset)
    );

    always_comb begin
        if (cfg_rd_slot) begin
            cfg_rdata = base[63:32];
        end else begin
            cfg_rdata = base[31:0] | {28'd0, ATTR};
        end
    end

    p_lo_slot_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_slot |-> ((cfg_rdata & LO_SPAN) == {28'd0, ATTR}));

    generate
        if (!IS_64) begin : g_narrow
            p_hi_slot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_rd_slot |-> (cfg_rdata == 32'd0));
        end
    endgenerate
endmodule

// File: tb/bar_window_tb.sv
module bar_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_en32 = 1'b0;
    logic        wr_slot = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_slot = 1'b0;
    logic        mem_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;

    logic [31:0] rdata;
    logic        hit;
    logic [7:0]  off;
    logic [31:0] rdata32;
    logic        hit32;
    logic [11:0] off32;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bar_window #(.IS_64(1'b1), .PREFETCH(1'b1), .SIZE_LOG2(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_slot(wr_slot),
        .cfg_wdata(wdata), .cfg_rd_slot(rd_slot), .cfg_rdata(rdata),
        .mem_en(mem_en), .req_valid(req_valid), .req_addr(req_addr),
        .hit(hit), .hit_offset(off)
    );

    bar_window #(.IS_64(1'b0), .PREFETCH(1'b0), .SIZE_LOG2(12)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en32), .cfg_wr_slot(wr_slot),
        .cfg_wdata(wdata), .cfg_rd_slot(rd_slot), .cfg_rdata(rdata32),
        .mem_en(mem_en), .req_valid(req_valid), .req_addr(req_addr),
        .hit(hit32), .hit_offset(off32)
    );

    // {addr, valid, en, expected hit, expected offset}; base 0x12_3456_7800, 256 B
    localparam int NV = 8;
    localparam logic [74:0] VEC [NV] = '{
        {64'h0000_0012_3456_7800, 1'b1, 1'b1, 1'b1, 8'h00},  // R6 low edge
        {64'h0000_0012_3456_78FF, 1'b1, 1'b1, 1'b1, 8'hFF},  // R7 high edge
        {64'h0000_0012_3456_7900, 1'b1, 1'b1, 1'b0, 8'h00},  // R9 just above
        {64'h0000_0012_3456_77FF, 1'b1, 1'b1, 1'b0, 8'h00},  // R9 just below
        {64'h0000_0013_3456_7800, 1'b1, 1'b1, 1'b0, 8'h00},  // R9 upper word
        {64'h0000_0012_3456_7842, 1'b1, 1'b0, 1'b0, 8'h00},  // R8 disabled
        {64'h0000_0012_3456_7842, 1'b0, 1'b1, 1'b0, 8'h00},  // R10 not valid
        {64'h0000_0012_3456_7810, 1'b1, 1'b1, 1'b1, 8'h10}   // R7 mid
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input bit narrow, input logic slot, input logic [31:0] d);
        @(negedge clk);
        wr_slot = slot;
        wdata   = d;
        if (narrow) wr_en32 = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_en32 = 1'b0;
    endtask

    task automatic read_slot(input logic slot);
        rd_slot = slot;
        #1;
    endtask

    task automatic request(input logic [63:0] a, input logic v, input logic e);
        @(negedge clk);
        req_addr  = a;
        req_valid = v;
        mem_en    = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 reset state and type bits
        read_slot(1'b0);
        check("R1 R2 slot0 after reset (64b)", rdata, 32'h0000_000C);
        check("R1 R2 slot0 after reset (32b)", rdata32, 32'h0);
        read_slot(1'b1);
        check("R1 slot1 after reset", rdata, 32'h0);
        check("R1 hit after reset", hit, 1'b0);

        // R3 sizing with all-ones
        cfg_write(1'b0, 1'b0, 32'hFFFF_FFFF);
        cfg_write(1'b0, 1'b1, 32'hFFFF_FFFF);
        read_slot(1'b0);
        check("R3 sizing slot0", rdata, 32'hFFFF_FF0C);
        read_slot(1'b1);
        check("R3 sizing slot1", rdata, 32'hFFFF_FFFF);

        // R4 independent slot updates
        cfg_write(1'b0, 1'b0, 32'h3456_78AB);
        read_slot(1'b1);
        check("R4 slot1 kept after slot0 write", rdata, 32'hFFFF_FFFF);
        cfg_write(1'b0, 1'b1, 32'h0000_0012);
        read_slot(1'b0);
        check("R4 slot0 kept after slot1 write", rdata, 32'h3456_780C);
        read_slot(1'b1);
        check("R4 slot1 updated", rdata, 32'h0000_0012);

        // Vector table: R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            request(VEC[i][74:11], VEC[i][10], VEC[i][9]);
            check($sformatf("R6 R8 R9 R10 hit vector %0d", i), hit, VEC[i][8]);
            if (VEC[i][8]) check($sformatf("R7 offset vector %0d", i), off, VEC[i][7:0]);
        end

        // R5 32-bit register: sizing and tied-off slot 1
        cfg_write(1'b1, 1'b0, 32'hFFFF_FFFF);
        cfg_write(1'b1, 1'b1, 32'hFFFF_FFFF);
        read_slot(1'b0);
        check("R3 R2 sizing 32b slot0", rdata32, 32'hFFFF_F000);
        read_slot(1'b1);
        check("R5 32b slot1 reads zero", rdata32, 32'h0);
        cfg_write(1'b1, 1'b0, 32'h8000_0123);
        read_slot(1'b0);
        check("R3 32b base programmed", rdata32, 32'h8000_0000);

        request(64'h0000_0000_8000_0ABC, 1'b1, 1'b1);
        check("R6 32b hit", hit32, 1'b1);
        check("R7 32b offset", off32, 12'hABC);
        request(64'h0000_0001_8000_0ABC, 1'b1, 1'b1);
        check("R9 32b high address bits", hit32, 1'b0);
        request(64'h0000_0000_8000_1ABC, 1'b1, 1'b1);
        check("R9 32b first bit above window", hit32, 1'b0);

        // R8 enable dropped on a matching address, then restored
        request(64'h0000_0012_3456_7801, 1'b1, 1'b0);
        check("R8 disabled on match", hit, 1'b0);
        request(64'h0000_0012_3456_7801, 1'b1, 1'b1);
        check("R8 re-enabled hit", hit, 1'b1);
        check("R7 re-enabled offset", off, 8'h01);

        // R1 reset mid-run clears the base
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_slot(1'b1);
        check("R1 slot1 after second reset", rdata, 32'h0);
        check("R1 hit after second reset", hit, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule